// File: doc/BRIEF.md
# Task Context Save/Load Sequencer

This block performs the memory traffic of a hardware task switch. When it is started, it stores the volatile state of the task being left into that task's context record. It then reads the full context record of the task being entered and presents that record as a parallel set of register outputs. A context record is 26 words (104 bytes) long. The requester supplies the byte base addresses of both records, the selector that identifies the outgoing record, and two qualifiers: whether a return link must be kept and whether address translation is active.

The block reaches memory through a single word-wide port. The port has a valid/ready request, a separate read-data valid, and at most one access outstanding at a time. For every read request there is also a page-present input. The block writes only the volatile fields. It never writes the fields that describe the task's fixed environment: the ring stack pairs, the translation base, the local table selector and the tail word. It adds the return link only on request. If any read of the incoming record reaches a page marked absent, the block abandons the switch and leaves the previously presented bundle intact. This case arises when the record runs over a page boundary into an absent page.

Top module: `ctx_switch_seq`

## Requirements
- R1: A `start_i` pulse while `busy_o` is low captures both bases, `prev_sel_i`, `ret_link_i` and `paging_on_i`, and `busy_o` is high on the next cycle. A `start_i` that arrives while `busy_o` is high has no effect on the accesses or the outcome.
- R2: When `ret_link_i` was set at start, the first write goes to offset 0x00 of the old record, with `prev_sel_i` in bits 15:0 and zero in bits 31:16. When it was clear, offset 0x00 is not written.
- R3: The outgoing context is written in ascending offset order: `out_eip_i` at 0x20, `out_eflags_i` at 0x24, then `out_gpr_i[0]` through `out_gpr_i[7]` at 0x28 through 0x44, each word 4 bytes after the previous one.
- R4: `out_seg_i[0]` through `out_seg_i[5]` are written to 0x48 through 0x5C in index order, each in bits 15:0 of its word with bits 31:16 zero.
- R5: Offsets 0x04–0x1C, 0x60 and 0x64 of the old record are never written, so a switch makes exactly 16 writes, or 17 when the return link is kept.
- R6: Every write comes before the first read. The reads then fetch new-record offsets 0x00 through 0x64 in ascending order. After a read is accepted, no request is made until `mem_rvalid_i` returns its data.
- R7: `done_o` is a one-cycle pulse. In that cycle the bundle shows the new record as follows:
  - `in_link_o` holds bits 15:0 of 0x00.
  - `in_ring_sp_o[r]` holds the word at 0x04+8r, and `in_ring_ss_o[r]` holds bits 15:0 of 0x08+8r.
  - `pdbr_o` holds the word at 0x1C.
  - `in_eip_o` and `in_eflags_o` hold the words at 0x20 and 0x24.
  - `in_gpr_o[k]` holds the word at 0x28+4k.
  - `in_seg_o[k]` holds bits 15:0 of 0x48+4k.
  - `in_ldt_o` holds bits 15:0 of 0x60.
- R8: `pdbr_load_o` is high in the `done_o` cycle only when `paging_on_i` was set at start. It is never high in any other cycle.
- R9: `dbg_trap_o` is high in the `done_o` cycle exactly when bit 0 of the new record's word at 0x64 is 1. It is never high in any other cycle.
- R10: `iomap_o` shows bits 31:16 of the new record's word at 0x64.
- R11: A read accepted while `page_ok_i` is low ends the switch. `fault_o` pulses one cycle after that acceptance, `done_o` stays low, no further request is made, and every bundle output keeps its earlier value. `page_ok_i` is ignored on writes.
- R12: After reset the block is idle, with `busy_o`, `done_o`, `fault_o` and `mem_req_o` low and a zero bundle. `busy_o` stays high up to and including the `done_o` or `fault_o` cycle, and is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a switch |
| old_base_i | input | ADDR_W | Byte base of outgoing record |
| new_base_i | input | ADDR_W | Byte base of incoming record |
| prev_sel_i | input | SEL_W | Selector stored as the return link |
| ret_link_i | input | 1 | Keep a return link |
| paging_on_i | input | 1 | Address translation active |
| out_eip_i | input | DATA_W | Outgoing instruction pointer |
| out_eflags_i | input | DATA_W | Outgoing flags |
| out_gpr_i | input | 8×DATA_W | Outgoing general registers |
| out_seg_i | input | 6×SEL_W | Outgoing segment selectors |
| mem_req_o | output | 1 | Request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ready_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DATA_W | Read data |
| page_ok_i | input | 1 | Page of the current read is present |
| busy_o | output | 1 | Switch in progress |
| done_o | output | 1 | Switch completed (pulse) |
| fault_o | output | 1 | Switch aborted on absent page (pulse) |
| dbg_trap_o | output | 1 | Debug trap requested (pulse) |
| pdbr_load_o | output | 1 | Load translation base (pulse) |
| in_eip_o | output | DATA_W | Incoming instruction pointer |
| in_eflags_o | output | DATA_W | Incoming flags |
| in_gpr_o | output | 8×DATA_W | Incoming general registers |
| in_seg_o | output | 6×SEL_W | Incoming segment selectors |
| in_ldt_o | output | SEL_W | Incoming local table selector |
| in_ring_sp_o | output | 3×DATA_W | Ring 0–2 stack pointers |
| in_ring_ss_o | output | 3×SEL_W | Ring 0–2 stack selectors |
| in_link_o | output | SEL_W | Incoming return link |
| pdbr_o | output | DATA_W | Incoming translation base |
| iomap_o | output | SEL_W | Incoming I/O map base |

## Verification
Five switch patterns are run. They mix the return-link and translation qualifiers, the trap bit, a memory that accepts only every other cycle, and absent-page limits at the first read and in the middle of the record. The link-on and link-off runs show whether offset 0x00 is written conditionally. The stalled runs show whether ordering and the single outstanding access survive back-pressure. The two fault positions show an abort before any data is captured and an abort after a partial capture; in both the earlier bundle must stay visible. One run also sends a second start with different bases in mid-switch, which must leave the write trace unchanged.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
    localparam int REC_WORDS = 26;
    localparam int IDX_W     = $clog2(REC_WORDS);
    localparam int N_GPR     = 8;
    localparam int N_SEG     = 6;
    localparam int N_RING    = 3;

    // word indices inside a context record (byte offset = index * 4)
    localparam int W_LINK  = 0;
    localparam int W_RING  = 1;
    localparam int W_XLAT  = 7;
    localparam int W_EIP   = 8;
    localparam int W_FLAGS = 9;
    localparam int W_GPR   = 10;
    localparam int W_SEG   = 18;
    localparam int W_LDT   = 24;
    localparam int W_TAIL  = 25;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_REQ,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_DONE,
        ST_FAULT
    } seq_st_e;
endpackage

// File: rtl/ctx_field_mux.sv
module ctx_field_mux
    import ctx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 16
) (
    input  logic [IDX_W-1:0]             idx_i,
    input  logic [SEL_W-1:0]             link_i,
    input  logic [DATA_W-1:0]            eip_i,
    input  logic [DATA_W-1:0]            eflags_i,
    input  logic [N_GPR-1:0][DATA_W-1:0] gpr_i,
    input  logic [N_SEG-1:0][SEL_W-1:0]  seg_i,
    output logic [DATA_W-1:0]            wdata_o
);
    always_comb begin
        wdata_o = '0;
        if (idx_i == IDX_W'(W_LINK)) begin
            wdata_o = DATA_W'(link_i);
        end
        if (idx_i == IDX_W'(W_EIP)) begin
            wdata_o = eip_i;
        end
        if (idx_i == IDX_W'(W_FLAGS)) begin
            wdata_o = eflags_i;
        end
        for (int k = 0; k < N_GPR; k++) begin
            if (idx_i == IDX_W'(W_GPR + k)) begin
                wdata_o = gpr_i[k];
            end
        end
        for (int k = 0; k < N_SEG; k++) begin
            if (idx_i == IDX_W'(W_SEG + k)) begin
                wdata_o = DATA_W'(seg_i[k]);
            end
        end
    end
endmodule

// File: rtl/ctx_stage_bank.sv
module ctx_stage_bank
    import ctx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                                 clk_i,
    input  logic                                 rst_ni,
    input  logic                                 cap_en_i,
    input  logic [IDX_W-1:0]                     cap_idx_i,
    input  logic [DATA_W-1:0]                    cap_data_i,
    input  logic                                 commit_i,
    output logic [REC_WORDS-1:0][DATA_W-1:0]     live_o
);
    logic [REC_WORDS-1:0][DATA_W-1:0] stage_d, stage_q;
    logic [REC_WORDS-1:0][DATA_W-1:0] live_d,  live_q;

    always_comb begin
        stage_d = stage_q;
        live_d  = live_q;
        for (int j = 0; j < REC_WORDS; j++) begin
            if (cap_en_i && cap_idx_i == IDX_W'(j)) begin
                stage_d[j] = cap_data_i;
            end
        end
        if (commit_i) begin
            live_d = stage_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage_q <= '0;
            live_q  <= '0;
        end else begin
            stage_q <= stage_d;
            live_q  <= live_d;
        end
    end

    assign live_o = live_q;

    // a commit only ever accompanies the capture of the last record word
    assert_commit_last_word_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_i |-> (cap_en_i && cap_idx_i == IDX_W'(REC_WORDS - 1)));

    // without a commit the presented bundle never moves
    assert_live_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !commit_i |=> $stable(live_q));
endmodule

// File: rtl/ctx_switch_seq.sv
module ctx_switch_seq
    import ctx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 16
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              start_i,
    input  logic [ADDR_W-1:0]                 old_base_i,
    input  logic [ADDR_W-1:0]                 new_base_i,
    input  logic [SEL_W-1:0]                  prev_sel_i,
    input  logic                              ret_link_i,
    input  logic                              paging_on_i,
    input  logic [DATA_W-1:0]                 out_eip_i,
    input  logic [DATA_W-1:0]                 out_eflags_i,
    input  logic [N_GPR-1:0][DATA_W-1:0]      out_gpr_i,
    input  logic [N_SEG-1:0][SEL_W-1:0]       out_seg_i,
    output logic                              mem_req_o,
    output logic                              mem_we_o,
    output logic [ADDR_W-1:0]                 mem_addr_o,
    output logic [DATA_W-1:0]                 mem_wdata_o,
    input  logic                              mem_ready_i,
    input  logic                              mem_rvalid_i,
    input  logic [DATA_W-1:0]                 mem_rdata_i,
    input  logic                              page_ok_i,
    output logic                              busy_o,
    output logic                              done_o,
    output logic                              fault_o,
    output logic                              dbg_trap_o,
    output logic                              pdbr_load_o,
    output logic [DATA_W-1:0]                 in_eip_o,
    output logic [DATA_W-1:0]                 in_eflags_o,
    output logic [N_GPR-1:0][DATA_W-1:0]      in_gpr_o,
    output logic [N_SEG-1:0][SEL_W-1:0]       in_seg_o,
    output logic [SEL_W-1:0]                  in_ldt_o,
    output logic [N_RING-1:0][DATA_W-1:0]     in_ring_sp_o,
    output logic [N_RING-1:0][SEL_W-1:0]      in_ring_ss_o,
    output logic [SEL_W-1:0]                  in_link_o,
    output logic [DATA_W-1:0]                 pdbr_o,
    output logic [SEL_W-1:0]                  iomap_o
);
    localparam int BYTE_SH  = $clog2(DATA_W / 8);
    localparam int LAST_WR  = W_SEG + N_SEG - 1;
    localparam int LAST_RD  = REC_WORDS - 1;

    typedef struct packed {
        seq_st_e            st;
        logic [IDX_W-1:0]   word;
        logic [ADDR_W-1:0]  old_base;
        logic [ADDR_W-1:0]  new_base;
        logic [SEL_W-1:0]   link;
        logic               ret;
        logic               pg;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic                             cap_en;
    logic                             commit;
    logic [REC_WORDS-1:0][DATA_W-1:0] live;
    logic [ADDR_W-1:0]                word_off;

    assign word_off   = ADDR_W'(s_q.word) << BYTE_SH;
    assign mem_req_o  = (s_q.st == ST_WR_REQ) || (s_q.st == ST_RD_REQ);
    assign mem_we_o   = (s_q.st == ST_WR_REQ);
    assign mem_addr_o = (mem_we_o ? s_q.old_base : s_q.new_base) + word_off;

    ctx_field_mux #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_field_mux (
        .idx_i    (s_q.word),
        .link_i   (s_q.link),
        .eip_i    (out_eip_i),
        .eflags_i (out_eflags_i),
        .gpr_i    (out_gpr_i),
        .seg_i    (out_seg_i),
        .wdata_o  (mem_wdata_o)
    );

    always_comb begin
        s_d    = s_q;
        cap_en = 1'b0;
        commit = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.st       = ST_WR_REQ;
                    s_d.word     = ret_link_i ? IDX_W'(W_LINK) : IDX_W'(W_EIP);
                    s_d.old_base = old_base_i;
                    s_d.new_base = new_base_i;
                    s_d.link     = prev_sel_i;
                    s_d.ret      = ret_link_i;
                    s_d.pg       = paging_on_i;
                end
            end
            ST_WR_REQ: begin
                if (mem_ready_i) begin
                    if (s_q.word == IDX_W'(W_LINK)) begin
                        s_d.word = IDX_W'(W_EIP);
                    end else if (s_q.word == IDX_W'(LAST_WR)) begin
                        s_d.st   = ST_RD_REQ;
                        s_d.word = '0;
                    end else begin
                        s_d.word = s_q.word + 1'b1;
                    end
                end
            end
            ST_RD_REQ: begin
                if (mem_ready_i) begin
                    s_d.st = page_ok_i ? ST_RD_WAIT : ST_FAULT;
                end
            end
            ST_RD_WAIT: begin
                if (mem_rvalid_i) begin
                    cap_en = 1'b1;
                    if (s_q.word == IDX_W'(LAST_RD)) begin
                        commit = 1'b1;
                        s_d.st = ST_DONE;
                    end else begin
                        s_d.word = s_q.word + 1'b1;
                        s_d.st   = ST_RD_REQ;
                    end
                end
            end
            ST_DONE:  s_d.st = ST_IDLE;
            ST_FAULT: s_d.st = ST_IDLE;
            default:  s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    ctx_stage_bank #(.DATA_W(DATA_W)) u_stage_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cap_en_i   (cap_en),
        .cap_idx_i  (s_q.word),
        .cap_data_i (mem_rdata_i),
        .commit_i   (commit),
        .live_o     (live)
    );

    assign busy_o      = (s_q.st != ST_IDLE);
    assign done_o      = (s_q.st == ST_DONE);
    assign fault_o     = (s_q.st == ST_FAULT);
    assign pdbr_load_o = done_o && s_q.pg;
    assign dbg_trap_o  = done_o && live[W_TAIL][0];

    assign in_link_o   = live[W_LINK][SEL_W-1:0];
    assign pdbr_o      = live[W_XLAT];
    assign in_eip_o    = live[W_EIP];
    assign in_eflags_o = live[W_FLAGS];
    assign in_ldt_o    = live[W_LDT][SEL_W-1:0];
    assign iomap_o     = live[W_TAIL][DATA_W-1 -: SEL_W];

    for (genvar k = 0; k < N_GPR; k++) begin : g_gpr
        assign in_gpr_o[k] = live[W_GPR + k];
    end
    for (genvar k = 0; k < N_SEG; k++) begin : g_seg
        assign in_seg_o[k] = live[W_SEG + k][SEL_W-1:0];
    end
    for (genvar r = 0; r < N_RING; r++) begin : g_ring
        assign in_ring_sp_o[r] = live[W_RING + 2*r];
        assign in_ring_ss_o[r] = live[W_RING + 2*r + 1][SEL_W-1:0];
    end

    logic unused_live_bits;
    assign unused_live_bits = ^{live[W_LINK][DATA_W-1:SEL_W], live[W_LDT][DATA_W-1:SEL_W],
                                live[W_TAIL][DATA_W-SEL_W-1:1],
                                live[W_RING+1][DATA_W-1:SEL_W], live[W_RING+3][DATA_W-1:SEL_W],
                                live[W_RING+5][DATA_W-1:SEL_W],
                                live[W_SEG][DATA_W-1:SEL_W], live[W_SEG+1][DATA_W-1:SEL_W],
                                live[W_SEG+2][DATA_W-1:SEL_W], live[W_SEG+3][DATA_W-1:SEL_W],
                                live[W_SEG+4][DATA_W-1:SEL_W], live[W_SEG+5][DATA_W-1:SEL_W]};

    // ---------------- assertions ----------------
    logic [ADDR_W-1:0] wr_off;
    logic              rd_seen_q;
    assign wr_off = mem_addr_o - s_q.old_base;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_seen_q <= 1'b0;
        end else if (!busy_o) begin
            rd_seen_q <= 1'b0;
        end else if (mem_req_o && !mem_we_o) begin
            rd_seen_q <= 1'b1;
        end
    end

    assert_busy_after_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> busy_o);

    assert_link_only_if_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && mem_we_o && wr_off == '0) |-> s_q.ret);

    assert_seg_upper_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && mem_we_o && wr_off >= ADDR_W'('h48)) |-> mem_wdata_o[DATA_W-1:SEL_W] == '0);

    assert_no_static_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && mem_we_o) |->
        (wr_off == '0 || (wr_off >= ADDR_W'('h20) && wr_off <= ADDR_W'('h5C))));

    assert_writes_before_reads_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_seen_q |-> !(mem_req_o && mem_we_o));

    assert_single_outstanding_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_we_o && mem_ready_i && page_ok_i) |=> !mem_req_o);

    assert_pdbr_only_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pdbr_load_o |-> done_o);

    assert_trap_only_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_trap_o |-> done_o);

    assert_fault_stops_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> (!mem_req_o && !done_o && $stable(in_eip_o)));

    assert_busy_held_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !done_o && !fault_o) |=> busy_o);

    assert_busy_drops_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o || fault_o) |=> !busy_o);
endmodule

// File: tb/ctx_switch_seq_bench.sv
`timescale 1ns/1ps
module ctx_switch_seq_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n;
    logic start;
    logic [31:0] old_base, new_base;
    logic [15:0] prev_sel;
    logic ret_link, paging_on;
    logic [31:0] out_eip, out_eflags;
    logic [7:0][31:0] out_gpr;
    logic [5:0][15:0] out_seg;
    logic mem_req, mem_we, mem_ready, mem_rvalid, page_ok;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic busy, done, fault, dbg_trap, pdbr_load;
    logic [31:0] in_eip, in_eflags, pdbr;
    logic [7:0][31:0] in_gpr;
    logic [5:0][15:0] in_seg;
    logic [15:0] in_ldt, in_link, iomap;
    logic [2:0][31:0] in_ring_sp;
    logic [2:0][15:0] in_ring_ss;

    ctx_switch_seq u_ctx_switch_seq (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .old_base_i(old_base), .new_base_i(new_base), .prev_sel_i(prev_sel),
        .ret_link_i(ret_link), .paging_on_i(paging_on),
        .out_eip_i(out_eip), .out_eflags_i(out_eflags), .out_gpr_i(out_gpr), .out_seg_i(out_seg),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_ready_i(mem_ready), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
        .page_ok_i(page_ok),
        .busy_o(busy), .done_o(done), .fault_o(fault), .dbg_trap_o(dbg_trap),
        .pdbr_load_o(pdbr_load),
        .in_eip_o(in_eip), .in_eflags_o(in_eflags), .in_gpr_o(in_gpr), .in_seg_o(in_seg),
        .in_ldt_o(in_ldt), .in_ring_sp_o(in_ring_sp), .in_ring_ss_o(in_ring_ss),
        .in_link_o(in_link), .pdbr_o(pdbr), .iomap_o(iomap)
    );

    // ---------------- memory model ----------------
    logic [31:0] mem [0:255];
    logic [31:0] cyc_q;
    logic        stall_mode, fault_on, log_clr;
    logic [31:0] fault_lim;
    logic        rv_q;
    logic [31:0] rd_q;
    logic [31:0] wr_a [0:31];
    logic [31:0] wr_d [0:31];
    logic [31:0] rd_a [0:31];
    int          n_wr, n_rd;
    logic        bad_order;
    logic        preload_en;
    logic [7:0]  preload_idx;
    logic [31:0] preload_val;

    assign mem_ready  = !stall_mode || cyc_q[0];
    assign page_ok    = !(fault_on && mem_addr >= fault_lim);
    assign mem_rvalid = rv_q;
    assign mem_rdata  = rd_q;

    always @(posedge clk) begin
        cyc_q <= cyc_q + 1;
        rv_q  <= 1'b0;
        if (preload_en) mem[preload_idx] <= preload_val;
        if (log_clr) begin
            n_wr <= 0; n_rd <= 0; bad_order <= 1'b0;
        end else if (mem_req && mem_ready) begin
            if (mem_we) begin
                mem[mem_addr[9:2]] <= mem_wdata;
                if (n_wr < 32) begin wr_a[n_wr] <= mem_addr; wr_d[n_wr] <= mem_wdata; end
                n_wr <= n_wr + 1;
                if (n_rd > 0) bad_order <= 1'b1;
            end else if (page_ok) begin
                rv_q <= 1'b1;
                rd_q <= mem[mem_addr[9:2]];
                if (n_rd < 32) rd_a[n_rd] <= mem_addr;
                n_rd <= n_rd + 1;
            end
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic        ret;
        logic        pg;
        logic        trap;
        logic        stall;
        logic        flt;
        logic        ign;
        logic [11:0] old_b;
        logic [11:0] new_b;
        logic [11:0] lim;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'h040, 12'h200, 12'h000},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 12'h080, 12'h300, 12'h000},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 12'h000, 12'h380, 12'h3C0},
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 12'h040, 12'h200, 12'h200},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 12'h100, 12'h000}
    };

    function automatic logic [31:0] rec_word(input int v, input int j, input logic trap);
        if (j == 25) return {16'hC000 + 16'(v), 15'h0, trap};
        return {8'(v + 1), 8'(j), 16'h5A00 + 16'(j)};
    endfunction

    function automatic logic [31:0] out_word(input int v, input int w);
        if (w == 0) return {16'h0, 16'h0A00 + 16'(v)};
        if (w == 8) return 32'hE100_0000 + 32'(v);
        if (w == 9) return 32'h0000_0202 + 32'(v << 12);
        if (w >= 10 && w < 18) return 32'h6000_0000 + 32'(v << 8) + 32'(w - 10);
        return {16'h0, 16'h0800 + 16'(v << 4) + 16'(w - 18)};
    endfunction

    logic wd_fired = 1'b0;

    task automatic run_vec(input int v);
        vec_t vc = VECS[v];
        int cycles = 0;
        int exp_wr = vc.ret ? 17 : 16;
        int exp_rd = vc.flt ? int'((vc.lim - vc.new_b) >> 2) : 26;
        int nw_done;
        logic [31:0] s_eip, s_pdbr, s_gpr0;
        logic [15:0] s_iomap, s_seg5;
        // preload the incoming record, one word per cycle
        for (int j = 0; j < 26; j++) begin
            @(negedge clk);
            preload_en  = 1'b1;
            preload_idx = 8'((32'(vc.new_b) >> 2) + j);
            preload_val = rec_word(v, j, vc.trap);
        end
        @(negedge clk);
        preload_en = 1'b0;
        stall_mode = vc.stall; fault_on = vc.flt; fault_lim = 32'(vc.lim);
        old_base = 32'(vc.old_b); new_base = 32'(vc.new_b);
        prev_sel = 16'h0A00 + 16'(v); ret_link = vc.ret; paging_on = vc.pg;
        out_eip = out_word(v, 8); out_eflags = out_word(v, 9);
        for (int k = 0; k < 8; k++) out_gpr[k] = out_word(v, 10 + k);
        for (int k = 0; k < 6; k++) out_seg[k] = out_word(v, 18 + k)[15:0];
        s_eip = in_eip; s_pdbr = pdbr; s_gpr0 = in_gpr[0]; s_iomap = iomap; s_seg5 = in_seg[5];
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk($sformatf("R1 busy after start v%0d", v), 32'(busy), 32'd1);
        while (!(done || fault) && cycles < 2000) begin
            @(negedge clk);
            cycles++;
            if (vc.ign && cycles == 3) begin
                start = 1'b1; old_base = 32'h3F0; new_base = 32'h000; ret_link = 1'b1;
            end
            if (vc.ign && cycles == 4) begin
                start = 1'b0; old_base = 32'(vc.old_b); new_base = 32'(vc.new_b); ret_link = vc.ret;
            end
        end
        if (cycles >= 2000) begin
            n_chk++; n_bad++;
            $display("FAIL R12 v%0d switch never ended actual=running expected=end", v);
        end
        chk($sformatf("R11 fault pulse v%0d", v), 32'(fault), 32'(vc.flt));
        chk($sformatf("R7 done pulse v%0d", v), 32'(done), 32'(!vc.flt));
        chk($sformatf("R12 busy in end cycle v%0d", v), 32'(busy), 32'd1);
        chk($sformatf("R5 write count v%0d", v), 32'(n_wr), 32'(exp_wr));
        for (int i = 0; i < exp_wr && i < n_wr; i++) begin
            int w = (vc.ret && i == 0) ? 0 : 8 + i - int'(vc.ret);
            string rq = (w == 0) ? "R2" : (w >= 18) ? "R4" : "R3";
            chk($sformatf("%s write addr v%0d i%0d", rq, v, i), wr_a[i], 32'(vc.old_b) + 32'(w * 4));
            chk($sformatf("%s write data v%0d i%0d", rq, v, i), wr_d[i], out_word(v, w));
        end
        chk($sformatf("R6 writes before reads v%0d", v), 32'(bad_order), 32'd0);
        chk($sformatf("R6 read count v%0d", v), 32'(n_rd), 32'(exp_rd));
        for (int i = 0; i < exp_rd && i < n_rd; i++) begin
            chk($sformatf("R6 read addr v%0d i%0d", v, i), rd_a[i], 32'(vc.new_b) + 32'(i * 4));
        end
        if (!vc.flt) begin
            chk($sformatf("R7 eip v%0d", v), in_eip, rec_word(v, 8, vc.trap));
            chk($sformatf("R7 eflags v%0d", v), in_eflags, rec_word(v, 9, vc.trap));
            for (int k = 0; k < 8; k++)
                chk($sformatf("R7 gpr%0d v%0d", k, v), in_gpr[k], rec_word(v, 10 + k, vc.trap));
            for (int k = 0; k < 6; k++)
                chk($sformatf("R7 seg%0d v%0d", k, v), 32'(in_seg[k]), 32'(rec_word(v, 18 + k, vc.trap)[15:0]));
            for (int r = 0; r < 3; r++) begin
                chk($sformatf("R7 ring sp%0d v%0d", r, v), in_ring_sp[r], rec_word(v, 1 + 2 * r, vc.trap));
                chk($sformatf("R7 ring ss%0d v%0d", r, v), 32'(in_ring_ss[r]),
                    32'(rec_word(v, 2 + 2 * r, vc.trap)[15:0]));
            end
            chk($sformatf("R7 ldt v%0d", v), 32'(in_ldt), 32'(rec_word(v, 24, vc.trap)[15:0]));
            chk($sformatf("R7 link v%0d", v), 32'(in_link), 32'(rec_word(v, 0, vc.trap)[15:0]));
            chk($sformatf("R7 pdbr v%0d", v), pdbr, rec_word(v, 7, vc.trap));
            chk($sformatf("R8 pdbr load v%0d", v), 32'(pdbr_load), 32'(vc.pg));
            chk($sformatf("R9 debug trap v%0d", v), 32'(dbg_trap), 32'(vc.trap));
            chk($sformatf("R10 iomap v%0d", v), 32'(iomap), 32'(16'hC000 + 16'(v)));
        end else begin
            chk($sformatf("R11 eip kept v%0d", v), in_eip, s_eip);
            chk($sformatf("R11 gpr0 kept v%0d", v), in_gpr[0], s_gpr0);
            chk($sformatf("R11 seg5 kept v%0d", v), 32'(in_seg[5]), 32'(s_seg5));
            chk($sformatf("R11 pdbr kept v%0d", v), pdbr, s_pdbr);
            chk($sformatf("R11 iomap kept v%0d", v), 32'(iomap), 32'(s_iomap));
            chk($sformatf("R8 no pdbr load on fault v%0d", v), 32'(pdbr_load), 32'd0);
            chk($sformatf("R9 no trap on fault v%0d", v), 32'(dbg_trap), 32'd0);
        end
        nw_done = n_wr;
        @(negedge clk);
        chk($sformatf("R12 busy low after end v%0d", v), 32'(busy), 32'd0);
        chk($sformatf("R12 pulse over v%0d", v), 32'({done, fault, pdbr_load, dbg_trap}), 32'd0);
        for (int i = 0; i < 4; i++) begin
            chk($sformatf("R1 idle no request v%0d c%0d", v, i), 32'(mem_req), 32'd0);
            @(negedge clk);
        end
        chk($sformatf("R1 no extra writes v%0d", v), 32'(n_wr), 32'(nw_done));
    endtask

    initial begin
        #(4 * 150000);
        wd_fired = 1'b1;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; old_base = '0; new_base = '0; prev_sel = '0;
        ret_link = 1'b0; paging_on = 1'b0; out_eip = '0; out_eflags = '0;
        out_gpr = '0; out_seg = '0; stall_mode = 1'b0; fault_on = 1'b0; fault_lim = '0;
        log_clr = 1'b1; preload_en = 1'b0; preload_idx = '0; preload_val = '0;
        cyc_q = '0; rv_q = 1'b0; rd_q = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        // reset state (R12)
        chk("R12 reset busy", 32'(busy), 32'd0);
        chk("R12 reset done/fault", 32'({done, fault}), 32'd0);
        chk("R12 reset request", 32'(mem_req), 32'd0);
        chk("R12 reset bundle eip", in_eip, 32'd0);
        chk("R12 reset bundle pdbr", pdbr, 32'd0);
        chk("R12 reset trap/load", 32'({dbg_trap, pdbr_load}), 32'd0);
        // vector table walk
        for (int v = 0; v < NV; v++) begin
            if (!wd_fired) run_vec(v);
        end
        // directed: a start arriving while busy has no effect (R1)
        @(negedge clk);
        chk("R1 idle before directed", 32'(busy), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule